// File: doc/BRIEF.md
# Nonvolatile SRAM Mode Controller

This block models a byte-wide static RAM that is backed by a shadow nonvolatile array of the same size. It watches four active-low control pins: nonvolatile enable (`ne_n`), chip enable (`ce_n`), write enable (`we_n`) and output enable (`oe_n`). One combinational decode turns the pin pattern into a mode. The ordinary modes are a read and a write to the RAM. The transfer modes are a save, which copies the whole RAM into the shadow array, and a restore, which copies the shadow array back into the RAM. The pins are sampled on `clk`.

A transfer starts only on the clock edge where the pin mode changes into the transfer pattern. Holding the pins in that pattern starts nothing more. While a transfer runs, `busy` is high, the data bus is released and every pin is ignored. A save first erases the shadow array to zero, one word per clock, and then programs it from the RAM, one word per clock. A restore first clears the RAM, then loads it from the shadow array, which is left unchanged. Each transfer ends with `SETTLE_CYC` idle settle cycles. A low-supply flag (`vcc_low`) latches a restore request, and so does reset. While the request is pending, no RAM access is served. Once `vcc_ok` is high and `vcc_low` is low, the restore starts by itself.

The sequencer has these states: `SQ_IDLE`, `SQ_ERASE`, `SQ_PROG`, `SQ_CLEAR`, `SQ_LOAD` and `SQ_SETTLE`. It makes these transitions:
- `SQ_IDLE`→`SQ_CLEAR` on an automatic restore (request pending, `vcc_ok` high, `vcc_low` low) or on a restore edge.
- `SQ_IDLE`→`SQ_ERASE` on a save edge.
- `SQ_ERASE`→`SQ_PROG` and `SQ_CLEAR`→`SQ_LOAD` after the last address.
- `SQ_PROG`/`SQ_LOAD`→`SQ_SETTLE` after the last address, or straight to `SQ_IDLE` when `SETTLE_CYC` is 0.
- `SQ_SETTLE`→`SQ_IDLE` after `SETTLE_CYC` cycles.

Top module: `nvram_ctrl`

## Requirements
- R1: In read mode (`ce_n`=0, `oe_n`=0, `ne_n`=1, `we_n`=1), when the block is idle and no restore is pending, `dq_oe` is 1 and `dq_out` shows the RAM word at `addr` within the same cycle.
- R2: In write mode (`ce_n`=0, `we_n`=0, `ne_n`=1), when the block is idle and no restore is pending, `dq_in` is written to `addr` on the clock edge. `dq_oe` stays 0 during the write, even with `oe_n` low.
- R3: A save (`ne_n`=0, `ce_n`=0, `we_n`=0, `oe_n`=1) holds `busy` high for exactly 2·DEPTH+SETTLE_CYC cycles. Afterwards the shadow array holds the RAM contents as they were at the start of the save.
- R4: A restore (`ne_n`=0, `ce_n`=0, `oe_n`=0, `we_n`=1) holds `busy` high for exactly 2·DEPTH+SETTLE_CYC cycles. Afterwards the RAM equals the shadow array, so any writes made after the last save are lost.
- R5: A save or restore starts only when the decoded pin mode changes into that pattern. Pins held in the pattern after a transfer completes leave `busy` at 0.
- R6: While `busy` is 1, `dq_oe` is 0 and a write pattern on the pins changes no RAM word.
- R7: A restore leaves the shadow array unchanged, so a second restore produces the same RAM contents as the first.
- R8: If the pins are in read mode when a transfer ends, `dq_oe` goes to 1 with valid data in the first cycle after `busy` falls.
- R9: After reset a restore is pending. Until `vcc_ok` is 1, `busy` stays 0 and `dq_oe` stays 0. Once `vcc_ok` is 1, the restore runs with the R4 duration.
- R10: A `vcc_low` pulse latches a new restore request. The request blocks access (`dq_oe` = 0) until the restore that starts on `vcc_ok` has finished. That restore brings back the last saved contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| vcc_low | input | 1 | Supply below the low threshold; latches a restore request |
| vcc_ok | input | 1 | Supply above the sense threshold; allows the automatic restore |
| ne_n | input | 1 | Nonvolatile enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Data bus, inbound half |
| dq_out | output | DATA_W | Data bus, outbound half |
| dq_oe | output | 1 | Drive enable for the data bus |
| busy | output | 1 | High for the whole of a save or restore |

## Verification
The bench drives a write pattern on the pins in the middle of a save. It then reads that address afterwards, so a design that leaked bus writes during a transfer shows a changed word. Pins are held in the save pattern past the end of the transfer; a level-triggered start would raise `busy` again. Writes made after a save are followed by a restore and a full read-back, which catches a restore that fails to clear or a save that only copied part of the array. A second restore, a read pattern left on the pins as a transfer ends, and a brown-out pulse check the following:
- that the shadow array is not consumed by a restore;
- that outputs come back without a fresh pin edge;
- that no access leaks through while the restore request is pending.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        PM_IDLE,
        PM_READ,
        PM_WRITE,
        PM_STORE,
        PM_RECALL
    } pin_mode_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ERASE,
        SQ_PROG,
        SQ_CLEAR,
        SQ_LOAD,
        SQ_SETTLE
    } seq_state_t;

endpackage

// File: rtl/nvs_decode.sv
module nvs_decode
    import nvs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ne_n,
    input  logic      ce_n,
    input  logic      we_n,
    input  logic      oe_n,
    output pin_mode_t mode,
    output logic      store_edge,
    output logic      recall_edge
);

    pin_mode_t mode_q;

    // Pin pattern to mode. Unselected chip or unused patterns decode as idle.
    always_comb begin
        mode = PM_IDLE;
        if (!ce_n) begin
            if (ne_n) begin
                if (!we_n)      mode = PM_WRITE;
                else if (!oe_n) mode = PM_READ;
            end else begin
                if (!we_n && oe_n)      mode = PM_STORE;
                else if (we_n && !oe_n) mode = PM_RECALL;
            end
        end
    end

    // Previous mode, tracked every cycle so that a pattern held through a
    // transfer never looks like a fresh entry afterwards.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= PM_IDLE;
        else        mode_q <= mode;
    end

    assign store_edge  = (mode == PM_STORE)  && (mode_q != PM_STORE);
    assign recall_edge = (mode == PM_RECALL) && (mode_q != PM_RECALL);

endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    // volatile array
    input  logic              ram_we,
    input  logic [ADDR_W-1:0] ram_waddr,
    input  logic [DATA_W-1:0] ram_wdata,
    input  logic [ADDR_W-1:0] ram_raddr_a,
    output logic [DATA_W-1:0] ram_rdata_a,
    input  logic [ADDR_W-1:0] ram_raddr_b,
    output logic [DATA_W-1:0] ram_rdata_b,
    // shadow array
    input  logic              nv_we,
    input  logic [ADDR_W-1:0] nv_addr,
    input  logic [DATA_W-1:0] nv_wdata,
    output logic [DATA_W-1:0] nv_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] ram_mem [DEPTH];
    logic [DATA_W-1:0] nv_mem  [DEPTH];

    always_ff @(posedge clk) begin
        if (ram_we) ram_mem[ram_waddr] <= ram_wdata;
    end

    always_ff @(posedge clk) begin
        if (nv_we) nv_mem[nv_addr] <= nv_wdata;
    end

    assign ram_rdata_a = ram_mem[ram_raddr_a];
    assign ram_rdata_b = ram_mem[ram_raddr_b];
    assign nv_rdata    = nv_mem[nv_addr];

endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vcc_low,
    input  logic              vcc_ok,
    input  pin_mode_t         mode,
    input  logic              store_edge,
    input  logic              recall_edge,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    input  logic [DATA_W-1:0] ram_rdata_b,
    input  logic [DATA_W-1:0] nv_rdata,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_waddr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              nv_we,
    output logic [DATA_W-1:0] nv_wdata,
    output logic              acc_en,
    output logic              busy,
    output logic              recall_pending
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int SW    = $clog2(SETTLE_CYC + 1);
    localparam int CNT_W = (ADDR_W > SW) ? ADDR_W : SW;
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(DEPTH - 1);
    localparam seq_state_t AFTER_XFER = (SETTLE_CYC > 0) ? SQ_SETTLE : SQ_IDLE;

    seq_state_t       state, state_d;
    logic [CNT_W-1:0] cnt, cnt_d;
    logic             req_q, req_d;
    logic             last_word, settle_done, auto_go;

    assign last_word = (cnt == LAST_ADDR);
    assign xfer_addr = cnt[ADDR_W-1:0];
    assign auto_go   = req_q && vcc_ok && !vcc_low;

    generate
        if (SETTLE_CYC > 0) begin : g_settle
            assign settle_done = (cnt == CNT_W'(SETTLE_CYC - 1));
        end else begin : g_no_settle
            assign settle_done = 1'b1;
        end
    endgenerate

    // Next-state and counter
    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        req_d   = req_q || vcc_low;
        unique case (state)
            SQ_IDLE: begin
                cnt_d = '0;
                if (auto_go) begin
                    state_d = SQ_CLEAR;
                    req_d   = 1'b0;
                end else if (!req_q && store_edge) begin
                    state_d = SQ_ERASE;
                end else if (!req_q && recall_edge) begin
                    state_d = SQ_CLEAR;
                end
            end
            SQ_ERASE: begin
                cnt_d = cnt + 1'b1;
                if (last_word) begin
                    state_d = SQ_PROG;
                    cnt_d   = '0;
                end
            end
            SQ_PROG: begin
                cnt_d = cnt + 1'b1;
                if (last_word) begin
                    state_d = AFTER_XFER;
                    cnt_d   = '0;
                end
            end
            SQ_CLEAR: begin
                cnt_d = cnt + 1'b1;
                if (last_word) begin
                    state_d = SQ_LOAD;
                    cnt_d   = '0;
                end
            end
            SQ_LOAD: begin
                cnt_d = cnt + 1'b1;
                if (last_word) begin
                    state_d = AFTER_XFER;
                    cnt_d   = '0;
                end
            end
            SQ_SETTLE: begin
                cnt_d = cnt + 1'b1;
                if (settle_done) begin
                    state_d = SQ_IDLE;
                    cnt_d   = '0;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // State register; reset models power-up and latches a restore request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            cnt   <= '0;
            req_q <= 1'b1;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            req_q <= req_d;
        end
    end

    // Outputs
    always_comb begin
        ram_we    = 1'b0;
        ram_waddr = addr;
        ram_wdata = dq_in;
        nv_we     = 1'b0;
        nv_wdata  = '0;
        acc_en    = 1'b0;
        busy      = 1'b1;
        unique case (state)
            SQ_IDLE: begin
                busy   = 1'b0;
                acc_en = !req_q;
                ram_we = !req_q && (mode == PM_WRITE);
            end
            SQ_ERASE: begin
                nv_we    = 1'b1;
                nv_wdata = '0;
            end
            SQ_PROG: begin
                nv_we    = 1'b1;
                nv_wdata = ram_rdata_b;
            end
            SQ_CLEAR: begin
                ram_we    = 1'b1;
                ram_waddr = xfer_addr;
                ram_wdata = '0;
            end
            SQ_LOAD: begin
                ram_we    = 1'b1;
                ram_waddr = xfer_addr;
                ram_wdata = nv_rdata;
            end
            SQ_SETTLE: begin
                busy = 1'b1;
            end
            default: busy = 1'b1;
        endcase
    end

    assign recall_pending = req_q;

endmodule

// File: rtl/nvram_ctrl.sv
module nvram_ctrl
    import nvs_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vcc_low,
    input  logic              vcc_ok,
    input  logic              ne_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              busy
);

    localparam int DEPTH = 1 << ADDR_W;

    pin_mode_t         mode;
    logic              store_edge, recall_edge;
    logic              ram_we, nv_we, acc_en, recall_pending;
    logic [ADDR_W-1:0] ram_waddr, xfer_addr;
    logic [DATA_W-1:0] ram_wdata, nv_wdata, ram_rdata_b, nv_rdata;

    nvs_decode u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .ne_n        (ne_n),
        .ce_n        (ce_n),
        .we_n        (we_n),
        .oe_n        (oe_n),
        .mode        (mode),
        .store_edge  (store_edge),
        .recall_edge (recall_edge)
    );

    nvs_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .vcc_low        (vcc_low),
        .vcc_ok         (vcc_ok),
        .mode           (mode),
        .store_edge     (store_edge),
        .recall_edge    (recall_edge),
        .addr           (addr),
        .dq_in          (dq_in),
        .ram_rdata_b    (ram_rdata_b),
        .nv_rdata       (nv_rdata),
        .ram_we         (ram_we),
        .ram_waddr      (ram_waddr),
        .ram_wdata      (ram_wdata),
        .xfer_addr      (xfer_addr),
        .nv_we          (nv_we),
        .nv_wdata       (nv_wdata),
        .acc_en         (acc_en),
        .busy           (busy),
        .recall_pending (recall_pending)
    );

    nvs_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk         (clk),
        .ram_we      (ram_we),
        .ram_waddr   (ram_waddr),
        .ram_wdata   (ram_wdata),
        .ram_raddr_a (addr),
        .ram_rdata_a (dq_out),
        .ram_raddr_b (xfer_addr),
        .ram_rdata_b (ram_rdata_b),
        .nv_we       (nv_we),
        .nv_addr     (xfer_addr),
        .nv_wdata    (nv_wdata),
        .nv_rdata    (nv_rdata)
    );

    assign dq_oe = acc_en && (mode == PM_READ);

endmodule

// File: rtl/nvs_chk.sv
module nvs_chk #(
    parameter int DEPTH      = 1024,
    parameter int SETTLE_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ne_n,
    input logic ce_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic busy,
    input logic req_q
);

    int unsigned blen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    blen <= 0;
        else if (busy) blen <= blen + 1;
        else           blen <= 0;
    end

    // R3 / R4: every transfer lasts two array passes plus settle
    a_r3_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (blen == 32'(2 * DEPTH + SETTLE_CYC)));

    // R6: bus released while a transfer runs
    a_r6_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dq_oe);

    // R2: no drive while a write pattern is on the pins
    a_r2_quiet_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |-> !dq_oe);

    // R9 / R10: pending restore blocks all access
    a_r9_pending_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> !dq_oe);

    // R1: a served read drives the bus
    a_r1_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_q && !ce_n && !oe_n && ne_n && we_n) |-> dq_oe);

endmodule

bind nvram_ctrl nvs_chk #(
    .DEPTH      (DEPTH),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ne_n  (ne_n),
    .ce_n  (ce_n),
    .we_n  (we_n),
    .oe_n  (oe_n),
    .dq_oe (dq_oe),
    .busy  (busy),
    .req_q (recall_pending)
);

// File: tb/nvram_ctrl_tb.sv
module nvram_ctrl_tb;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int D  = 1 << AW;
    localparam int ST = 3;
    localparam int BL = 2 * D + ST;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0, vcc_low = 1'b0, vcc_ok = 1'b0;
    logic          ne_n = 1'b1, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe, busy;

    nvram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETTLE_CYC(ST)) u_dut (
        .clk(clk), .rst_n(rst_n), .vcc_low(vcc_low), .vcc_ok(vcc_ok),
        .ne_n(ne_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [DW-1:0] d;
        string         tag;
    } rd_item_t;

    rd_item_t      sbq[$];
    logic [DW-1:0] ref_ram[D];
    logic [DW-1:0] ref_nv[D];

    function automatic logic [DW-1:0] pat(int a);
        return DW'(a * 7 + 3);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Scoreboard monitor: one queued read is compared after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                rd_item_t it;
                it = sbq.pop_front();
                chk(dq_oe === 1'b1 && dq_out === it.d, it.tag, {dq_oe, dq_out}, {1'b1, it.d});
            end
        end
    end

    task automatic set_idle();
        @(negedge clk);
        ce_n = 1'b1; ne_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic do_write(int a, logic [DW-1:0] d);
        @(negedge clk);
        ne_n = 1'b1; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        addr = AW'(a); dq_in = d;
        #1 chk(dq_oe == 1'b0, "R2 bus released during write", dq_oe, 0);
    endtask

    task automatic do_read(int a, string tag);
        rd_item_t it;
        @(negedge clk);
        ne_n = 1'b1; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        addr = AW'(a);
        it.d = ref_ram[a]; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic pins_store();
        @(negedge clk);
        ne_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    endtask

    task automatic pins_recall();
        @(negedge clk);
        ne_n = 1'b0; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    endtask

    // Counts busy cycles at falling edges; returns at the first idle one
    task automatic measure_busy(output int n);
        int g = 0;
        n = 0;
        while (!busy && g < 200) begin @(negedge clk); g++; end
        while (busy && n < 10000) begin n++; @(negedge clk); end
    endtask

    task automatic drain();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        // ---- power-up: R9
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R9 busy low while restore pending", busy, 0);
        @(negedge clk);
        ne_n = 1'b1; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(dq_oe == 1'b0 && busy == 1'b0, "R9 no access before supply good", {busy, dq_oe}, 0);
        end
        set_idle();
        vcc_ok = 1'b1;
        measure_busy(n);
        chk(n == BL, "R9 power-up restore length", n, BL);

        // ---- writes and reads: R1 R2
        for (int a = 0; a < D; a++) begin
            do_write(a, pat(a));
            ref_ram[a] = pat(a);
        end
        for (int a = 0; a < D; a++) do_read(a, "R1/R2 read back written word");
        drain();

        // ---- save with write pattern during busy: R3 R6 R8
        set_idle();
        pins_store();
        for (int a = 0; a < D; a++) ref_nv[a] = ref_ram[a];
        @(negedge clk);
        chk(busy == 1'b1, "R3 save starts on pin edge", busy, 1);
        repeat (3) begin
            @(negedge clk);
            ne_n = 1'b1; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
            addr = AW'(5); dq_in = 8'hEE;
            #1 chk(dq_oe == 1'b0, "R6 bus released while busy", dq_oe, 0);
        end
        @(negedge clk);
        ne_n = 1'b1; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = AW'(2);
        n = 4;
        while (busy && n < 10000) begin n++; @(negedge clk); end
        chk(n == BL, "R3 save length", n, BL);
        chk(dq_oe == 1'b1 && dq_out == ref_ram[2], "R8 read active right after save",
            {dq_oe, dq_out}, {1'b1, ref_ram[2]});
        do_read(5, "R6 write during save ignored");
        drain();

        // ---- held save pattern: R5
        set_idle();
        pins_store();
        measure_busy(n);
        chk(n == BL, "R3 second save length", n, BL);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(busy == 1'b0, "R5 held save pattern does not restart", busy, 0);
        end

        // ---- writes after save, then restore: R4
        set_idle();
        for (int a = 0; a < D; a += 3) begin
            do_write(a, ~pat(a));
            ref_ram[a] = ~pat(a);
        end
        do_read(0, "R2 overwrite visible before restore");
        drain();
        set_idle();
        pins_recall();
        measure_busy(n);
        chk(n == BL, "R4 restore length", n, BL);
        for (int a = 0; a < D; a++) ref_ram[a] = ref_nv[a];
        for (int a = 0; a < D; a++) do_read(a, "R4 restore brings back saved data");
        drain();

        // ---- repeat restore: R7
        set_idle();
        do_write(7, 8'h5A);
        set_idle();
        pins_recall();
        measure_busy(n);
        chk(n == BL, "R7 second restore length", n, BL);
        for (int a = 0; a < D; a++) do_read(a, "R7 shadow unchanged by restore");
        drain();

        // ---- brown-out: R10
        set_idle();
        @(negedge clk);
        vcc_low = 1'b1; vcc_ok = 1'b0;
        @(negedge clk);
        vcc_low = 1'b0;
        do_write(1, 8'h99);
        @(negedge clk);
        ne_n = 1'b1; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = AW'(1);
        #1 chk(dq_oe == 1'b0 && busy == 1'b0, "R10 access blocked while restore pending",
               {busy, dq_oe}, 0);
        set_idle();
        vcc_ok = 1'b1;
        measure_busy(n);
        chk(n == BL, "R10 brown-out restore length", n, BL);
        for (int a = 0; a < D; a++) do_read(a, "R10 saved data after brown-out");
        drain();

        done = 1'b1;
        finish_run();
    end

endmodule